// File: doc/BRIEF.md
# Per-Channel Protection Fault Manager

This block keeps the protection state for every channel of a multi-channel low-side switch. For each channel it takes the commanded output bit, a raw current-limit indication and an open-load comparator result. It filters overcurrent and open-load conditions with cycle-count deglitch timers and keeps one latch for each kind of fault. After an overcurrent trip it holds the channel off for a fixed retry time and then releases it. The two latches clear under opposite conditions. Clearing the output bit clears the overcurrent latch. Setting the output bit clears the open-load latch.

For each channel the block produces a drive enable, which feeds the gate stage, and a combined fault bit, which is read back serially. It also produces one active-low fault line for the system. A die overtemperature flag forces every channel off while it is asserted and leaves the latches untouched. An undervoltage flag, or the external clear request, forces every channel off and wipes all protection state.

All of these pins are plain control and status levels. There is no data stream, so no valid/ready handshake is used. Every duration is a parameter counted in system clock cycles.

Top module: `prot_fault_mgr`

## Requirements
- R1: `drive_en[i]` is 1 exactly when all of these hold: `out_cmd[i]` is 1, `enable_n` is 0, channel i is not disabled by overcurrent, `otemp` is 0 and `uvlo` is 0. The output is combinational on these inputs.
- R2: If `ilim_raw[i]` is high while `drive_en[i]` is 1 on OC_DGL consecutive clock edges, then at that OC_DGL-th edge channel i sets its overcurrent latch and becomes disabled. Any cycle without the condition restarts the count.
- R3: An overcurrent-disabled channel stays off for exactly RETRY clock edges after the trip edge. From the RETRY-th of those edges on, it drives again if it is still commanded.
- R4: The overcurrent latch of channel i is cleared at every edge where `out_cmd[i]` is 0. While `out_cmd[i]` stays 1, the latch survives the retry release.
- R5: If `ol_low[i]` is high while `out_cmd[i]` is 0 on OL_DGL consecutive edges, then channel i's open-load latch is set at that OL_DGL-th edge. Any cycle without the condition restarts the count.
- R6: The open-load latch of channel i is cleared at every edge where `out_cmd[i]` is 1. While `out_cmd[i]` is 1, `ol_low[i]` has no effect.
- R7: `fault_bits[i]` is the OR of channel i's overcurrent latch and open-load latch.
- R8: `fault_n` is 0 whenever any bit of `fault_bits` is 1 or `otemp` is 1. Otherwise it is 1.
- R9: While `otemp` is 1, every `drive_en` bit is 0. Driving resumes in the same cycle that `otemp` falls. The fault latches are kept.
- R10: `clr_req` high at an edge clears every latch, deglitch count and retry timer. A disabled channel can drive again right after that edge.
- R11: While `uvlo` is 1, every `drive_en` bit is 0 and all latches and timers are held cleared.
- R12: After `rst_n` is asserted, `drive_en` and `fault_bits` are all 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_req | input | 1 | Synchronous clear of all protection state, active high |
| uvlo | input | 1 | Supply undervoltage flag, active high |
| otemp | input | 1 | Die overtemperature flag, active high |
| enable_n | input | 1 | Global output enable, active low |
| out_cmd | input | NCH | Commanded output bit per channel |
| ilim_raw | input | NCH | Raw current-limit indication per channel |
| ol_low | input | NCH | Open-load comparator: output pin below threshold |
| drive_en | output | NCH | Gate drive enable per channel |
| fault_bits | output | NCH | Combined fault bit per channel for readback |
| fault_n | output | 1 | System fault line, active low |

## Verification
The hardest situation to reach is a channel that has already tripped and is still commanded on while the current limit persists. Reaching it needs the retry release, followed by a second deglitch run and a re-trip, with the overcurrent latch held throughout. The directed part holds `ilim_raw` high across the whole retry window and checks the exact release edge. The random part biases `ilim_raw` high and changes `out_cmd` only rarely, so long trip/retry/re-trip chains mix with clear, undervoltage and overtemperature events. Each cycle is compared against a reference model written in the bench.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  // Per-channel fault latches.
  typedef struct packed {
    logic oc_lat;
    logic ol_lat;
  } chan_latch_t;

  // Width of a counter holding 0 .. n-1.
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pfm_deglitch.sv
module pfm_deglitch #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic fire
);
  localparam int W = pfm_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] run_q;

  // Counts consecutive cycles of cond and saturates at TOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || !cond) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign fire = cond && !clr && (run_q == TOP);
endmodule

// File: rtl/pfm_retry.sv
module pfm_retry #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy
);
  localparam int W = pfm_pkg::cnt_width(CYCLES);
  localparam logic [W-1:0] TOP = W'(CYCLES - 1);

  logic [W-1:0] left_q;
  logic         busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      left_q <= TOP;
    end else if (busy_q) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pfm_channel.sv
module pfm_channel #(
  parameter int OC_DGL = 16,
  parameter int OL_DGL = 12,
  parameter int RETRY  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_clr,
  input  logic gate_ok,
  input  logic cmd,
  input  logic ilim,
  input  logic ol_low,
  output logic drive,
  output logic fault_bit
);
  pfm_pkg::chan_latch_t lat_q;
  logic oc_off;
  logic oc_fire;
  logic ol_fire;

  assign drive = cmd && gate_ok && !oc_off;

  pfm_deglitch #(.LIMIT(OC_DGL)) u_oc_dgl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hard_clr),
    .cond  (ilim && drive),
    .fire  (oc_fire)
  );

  pfm_deglitch #(.LIMIT(OL_DGL)) u_ol_dgl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hard_clr),
    .cond  (ol_low && !cmd),
    .fire  (ol_fire)
  );

  pfm_retry #(.CYCLES(RETRY)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hard_clr),
    .start (oc_fire),
    .busy  (oc_off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (hard_clr) begin
      lat_q <= '0;
    end else begin
      lat_q.oc_lat <= cmd ? (lat_q.oc_lat || oc_fire) : 1'b0;
      lat_q.ol_lat <= cmd ? 1'b0 : (lat_q.ol_lat || ol_fire);
    end
  end

  assign fault_bit = lat_q.oc_lat || lat_q.ol_lat;
endmodule

// File: rtl/prot_fault_mgr.sv
module prot_fault_mgr #(
  parameter int NCH    = 4,
  parameter int OC_DGL = 16,
  parameter int OL_DGL = 12,
  parameter int RETRY  = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_req,
  input  logic           uvlo,
  input  logic           otemp,
  input  logic           enable_n,
  input  logic [NCH-1:0] out_cmd,
  input  logic [NCH-1:0] ilim_raw,
  input  logic [NCH-1:0] ol_low,
  output logic [NCH-1:0] drive_en,
  output logic [NCH-1:0] fault_bits,
  output logic           fault_n
);
  logic hard_clr;
  logic gate_ok;

  assign hard_clr = clr_req || uvlo;
  assign gate_ok  = !enable_n && !otemp && !uvlo;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pfm_channel #(
      .OC_DGL (OC_DGL),
      .OL_DGL (OL_DGL),
      .RETRY  (RETRY)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .hard_clr  (hard_clr),
      .gate_ok   (gate_ok),
      .cmd       (out_cmd[g]),
      .ilim      (ilim_raw[g]),
      .ol_low    (ol_low[g]),
      .drive     (drive_en[g]),
      .fault_bit (fault_bits[g])
    );
  end

  assign fault_n = !((|fault_bits) || otemp);
endmodule

// File: rtl/pfm_checker.sv
module pfm_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_req,
  input logic           uvlo,
  input logic           otemp,
  input logic           enable_n,
  input logic [NCH-1:0] out_cmd,
  input logic [NCH-1:0] drive_en,
  input logic [NCH-1:0] fault_bits,
  input logic           fault_n
);
  // R1: a channel never drives unless commanded and globally enabled.
  p_drive_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_en & ~out_cmd) == '0) && !(enable_n && (drive_en != '0)));

  // R9: overtemperature forces all drives off.
  p_otemp_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    otemp |-> (drive_en == '0));

  // R11: undervoltage forces all drives off.
  p_uvlo_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> (drive_en == '0));

  // R11: undervoltage leaves no fault latched.
  p_uvlo_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (fault_bits == '0));

  // R10: a clear request leaves no fault latched.
  p_clr_wipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (fault_bits == '0));

  // R8: any fault or overtemperature pulls the fault line low.
  p_fault_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_bits != '0) || otemp) |-> !fault_n);
endmodule

bind prot_fault_mgr pfm_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_req    (clr_req),
  .uvlo       (uvlo),
  .otemp      (otemp),
  .enable_n   (enable_n),
  .out_cmd    (out_cmd),
  .drive_en   (drive_en),
  .fault_bits (fault_bits),
  .fault_n    (fault_n)
);

// File: tb/prot_fault_mgr_tb.sv
`timescale 1ns/1ps
module prot_fault_mgr_tb;
  localparam int NCH = 4;
  localparam int OC  = 5;
  localparam int OL  = 4;
  localparam int RT  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_req = 1'b0, uvlo = 1'b0, otemp = 1'b0, enable_n = 1'b0;
  logic [NCH-1:0] out_cmd = '0, ilim_raw = '0, ol_low = '0;
  logic [NCH-1:0] drive_en, fault_bits;
  logic fault_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  prot_fault_mgr #(.NCH(NCH), .OC_DGL(OC), .OL_DGL(OL), .RETRY(RT)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .uvlo(uvlo), .otemp(otemp),
    .enable_n(enable_n), .out_cmd(out_cmd), .ilim_raw(ilim_raw), .ol_low(ol_low),
    .drive_en(drive_en), .fault_bits(fault_bits), .fault_n(fault_n)
  );

  // Reference model built from the requirements.
  logic [NCH-1:0] m_oc = '0, m_ol = '0, m_off = '0;
  int m_occ [NCH];
  int m_olc [NCH];
  int m_rc  [NCH];

  function automatic logic [NCH-1:0] exp_drive();
    if (enable_n || otemp || uvlo) return '0;
    return out_cmd & ~m_off;
  endfunction

  function automatic logic exp_fault_n();
    return !(((m_oc | m_ol) != '0) || otemp);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [NCH-1:0] d;
    d = exp_drive();
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n || clr_req || uvlo) begin
        m_oc[c] = 1'b0; m_ol[c] = 1'b0; m_off[c] = 1'b0;
        m_occ[c] = 0; m_olc[c] = 0; m_rc[c] = 0;
      end else begin
        if (m_off[c]) begin
          m_rc[c]++;
          if (m_rc[c] == RT) m_off[c] = 1'b0;
        end
        if (ilim_raw[c] && d[c]) begin
          m_occ[c]++;
          if (m_occ[c] >= OC) begin
            m_oc[c] = 1'b1; m_off[c] = 1'b1; m_rc[c] = 0; m_occ[c] = 0;
          end
        end else begin
          m_occ[c] = 0;
        end
        if (!out_cmd[c]) m_oc[c] = 1'b0;
        if (out_cmd[c]) begin
          m_ol[c] = 1'b0; m_olc[c] = 0;
        end else if (ol_low[c]) begin
          m_olc[c]++;
          if (m_olc[c] >= OL) m_ol[c] = 1'b1;
        end else begin
          m_olc[c] = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Random-phase comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      #2;
      chk("R1 drive", 32'(drive_en), 32'(exp_drive()));
      chk("R7 fault bits", 32'(fault_bits), 32'(m_oc | m_ol));
      chk("R8 fault line", 32'(fault_n), 32'(exp_fault_n()));
    end
  end

  initial begin
    void'($urandom(32'd5150));
    tick(3);
    chk("R12 drive", 32'(drive_en), 0);
    chk("R12 bits", 32'(fault_bits), 0);
    chk("R12 line", 32'(fault_n), 1);
    @(negedge clk); rst_n = 1'b1;
    out_cmd = 4'b0001; #1;
    chk("R1 on", 32'(drive_en), 32'h1);
    enable_n = 1'b1; #1;
    chk("R1 enable_n", 32'(drive_en), 0);
    enable_n = 1'b0;

    // R2 deglitch restart, then trip
    @(negedge clk); ilim_raw = 4'b0001;
    tick(OC - 1);
    ilim_raw = '0;
    tick(1);
    chk("R2 short run", 32'(fault_bits), 0);
    ilim_raw = 4'b0001;
    tick(OC - 1);
    chk("R2 restart", 32'(drive_en), 32'h1);
    tick(1);
    chk("R2 trip bits", 32'(fault_bits), 32'h1);
    chk("R2 trip drive", 32'(drive_en), 0);
    chk("R8 line low", 32'(fault_n), 0);

    // R3 retry window, R4 latch persistence
    tick(RT - 1);
    chk("R3 still off", 32'(drive_en), 0);
    tick(1);
    chk("R3 released", 32'(drive_en), 32'h1);
    chk("R4 latch kept", 32'(fault_bits), 32'h1);
    tick(OC);
    chk("R3 re-trip", 32'(drive_en), 0);
    ilim_raw = '0;
    out_cmd = '0;
    tick(1);
    chk("R4 cleared", 32'(fault_bits), 0);
    chk("R8 line high", 32'(fault_n), 1);
    tick(RT);

    // R5 open-load deglitch, R6 clear
    ol_low = 4'b0010;
    tick(OL - 1);
    chk("R5 short run", 32'(fault_bits), 0);
    ol_low = '0;
    tick(1);
    ol_low = 4'b0010;
    tick(OL - 1);
    chk("R5 restart", 32'(fault_bits), 0);
    tick(1);
    chk("R5 set", 32'(fault_bits), 32'h2);
    chk("R8 line ol", 32'(fault_n), 0);
    out_cmd = 4'b0010;
    tick(1);
    chk("R6 cleared", 32'(fault_bits), 0);
    tick(10);
    chk("R6 ignored", 32'(fault_bits), 0);
    chk("R6 drive", 32'(drive_en), 32'h2);

    // R9 overtemperature
    ol_low = 4'b0110;
    tick(OL);
    chk("R9 pre bits", 32'(fault_bits), 32'h4);
    otemp = 1'b1; #1;
    chk("R9 off", 32'(drive_en), 0);
    chk("R9 line", 32'(fault_n), 0);
    tick(3);
    otemp = 1'b0; #1;
    chk("R9 resume", 32'(drive_en), 32'h2);
    chk("R9 latch kept", 32'(fault_bits), 32'h4);

    // R10 clear request
    ol_low = '0;
    clr_req = 1'b1;
    tick(1);
    clr_req = 1'b0;
    chk("R10 latches", 32'(fault_bits), 0);
    ilim_raw = 4'b0010;
    tick(OC);
    chk("R10 tripped", 32'(drive_en), 0);
    ilim_raw = '0;
    clr_req = 1'b1;
    tick(1);
    clr_req = 1'b0; #1;
    chk("R10 retry cut", 32'(drive_en), 32'h2);
    chk("R10 bits", 32'(fault_bits), 0);

    // R11 undervoltage
    ilim_raw = 4'b0010;
    tick(OC);
    ilim_raw = '0;
    uvlo = 1'b1; #1;
    chk("R11 off", 32'(drive_en), 0);
    out_cmd = '0;
    ol_low = 4'b1111;
    tick(10);
    chk("R11 held", 32'(fault_bits), 0);
    chk("R11 line", 32'(fault_n), 1);
    uvlo = 1'b0;
    ol_low = '0;

    // Random phase
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cmp_on = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(15) == 0) out_cmd[c] = ~out_cmd[c];
        if ($urandom_range(7) == 0) ilim_raw[c] = ($urandom_range(3) != 0);
        if ($urandom_range(9) == 0) ol_low[c] = ~ol_low[c];
      end
      otemp    = ($urandom_range(99) < 3) ? ~otemp : otemp;
      enable_n = ($urandom_range(199) == 0) ? ~enable_n : enable_n;
      clr_req  = ($urandom_range(299) == 0);
      uvlo     = ($urandom_range(399) == 0);
    end
    @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule